// File: doc/BRIEF.md
# Simple Edge Deblocking Filter Core

This block smooths one block edge of a decoded picture. Sixteen lanes run side by side, one lane per pixel position along the edge. Each lane gets four unsigned 8-bit samples that lie across the edge: two on the near side (`p1` outer, `p0` inner) and two on the far side (`q0` inner, `q1` outer). One 8-bit activity limit is shared by all lanes. A lane whose local step is small enough counts as a coding artefact, and its two inner samples are pulled toward each other. A lane whose step is larger counts as a real image feature and is left as it is.

The block is a fixed-latency pipeline. A beat presented with `in_valid` comes out three clock edges later with `out_valid`, carrying the new inner samples of every lane. The outer samples are read but never rewritten, so the caller keeps its own copies. The caller chooses which pixels to feed and where to write the results back, so the same core serves both horizontal and vertical edges.

Top module: `sdf_core`

## Requirements
- R1: A lane is filtered exactly when `min(255, min(255, 2*|p0-q0|) + (|p1-q1| >> 1)) <= limit`, where every unsigned sum saturates at 255 and all values are unsigned.
- R2: The base correction is computed in the signed domain, where each sample is XORed with 0x80. `a` starts as `clamp(p1-q1)`, and then `clamp(q0-p0)` is added to it three times in turn. Each step clamps to -128..127.
- R3: When a lane is not filtered its base correction is zero, so its new p0 equals p0 and its new q0 equals q0.
- R4: The far-side step is `f1 = clamp(a+4) >>> 3` and the near-side step is `f2 = clamp(a+3) >>> 3`. Both shifts are arithmetic, so a negative `a` gives a negative step.
- R5: The new q0 is `clamp0_255(q0 - f1)` and the new p0 is `clamp0_255(p0 + f2)`.
- R6: `out_valid` is high exactly when `in_valid` was sampled high at the third rising edge before, counting only edges after reset has been released. The data outputs belong to that beat.
- R7: A synchronous active-high `rst` clears every valid stage, so `out_valid` is low in the cycle after any edge at which `rst` was sampled high, and beats in flight are dropped.
- R8: Lane i uses bits `[8*i+7:8*i]` of every pixel bus, and its result depends only on its own four samples and the shared limit.
- R9: With a limit of 0, a lane with `p0 != q0` is left unchanged. A lane with `p0 == q0` and `p1 == q1` is left unchanged whatever the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input beat strobe |
| in_p1 | input | 128 | Outer near-side samples, lane i in bits [8i+7:8i] |
| in_p0 | input | 128 | Inner near-side samples |
| in_q0 | input | 128 | Inner far-side samples |
| in_q1 | input | 128 | Outer far-side samples |
| in_limit | input | 8 | Shared edge activity limit |
| out_valid | output | 1 | Result strobe, three edges after the input beat |
| out_p0 | output | 128 | New inner near-side samples |
| out_q0 | output | 128 | New inner far-side samples |

## Verification
The properties assume that `in_valid` and the lane-0 samples are always driven to known values, including while reset is held. They also assume that the stream is continuous, so a result can be matched to the beat three edges earlier without any handshake. The bench drives every input from time zero and changes inputs only on falling edges. It keeps `in_valid` low during each reset and mixes bubble cycles into the stream. This lets the latency property see both high and low strobes.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

    localparam int PIX_W = 8;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic signed [PIX_W-1:0] spix_t;

    // four samples straddling the edge for one lane
    typedef struct packed {
        pix_t p1;
        pix_t p0;
        pix_t q0;
        pix_t q1;
    } quad_t;

    // middle-stage state for one lane
    typedef struct packed {
        spix_t corr;
        pix_t  p0;
        pix_t  q0;
    } gate_t;

    // result for one lane
    typedef struct packed {
        pix_t p0;
        pix_t q0;
    } pair_t;

    function automatic spix_t bias_flip(input pix_t x);
        return spix_t'(x ^ 8'h80);
    endfunction

    function automatic spix_t clip_s(input logic signed [PIX_W:0] s);
        if (s > 9'sd127)
            return 8'sh7F;
        else if (s < -9'sd128)
            return 8'sh80;
        else
            return s[PIX_W-1:0];
    endfunction

    function automatic spix_t sadd(input spix_t x, input spix_t y);
        return clip_s({x[PIX_W-1], x} + {y[PIX_W-1], y});
    endfunction

    function automatic spix_t ssub(input spix_t x, input spix_t y);
        return clip_s({x[PIX_W-1], x} - {y[PIX_W-1], y});
    endfunction

    function automatic pix_t uadd_sat(input pix_t x, input pix_t y);
        logic [PIX_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[PIX_W] ? {PIX_W{1'b1}} : s[PIX_W-1:0];
    endfunction

    function automatic pix_t absdiff(input pix_t x, input pix_t y);
        return (x > y) ? (x - y) : (y - x);
    endfunction

    function automatic pix_t clip_u(input logic signed [PIX_W+1:0] s);
        if (s < 0)
            return '0;
        else if (s > 10'sd255)
            return {PIX_W{1'b1}};
        else
            return s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/sdf_gate.sv
module sdf_gate
    import sdf_pkg::*;
(
    input  quad_t lane_in,
    input  pix_t  limit,
    output gate_t gate_out
);
    pix_t  step_in, step_out, twice, half, activity;
    logic  pass;
    spix_t sp1, sp0, sq0, sq1;
    spix_t outer, inner, acc1, acc2, acc3;

    always_comb begin
        // edge activity measure, unsigned saturating
        step_in  = absdiff(lane_in.p0, lane_in.q0);
        step_out = absdiff(lane_in.p1, lane_in.q1);
        twice    = uadd_sat(step_in, step_in);
        half     = (step_out & 8'hFE) >> 1;
        activity = uadd_sat(twice, half);
        pass     = (activity <= limit);

        // signed-domain correction
        sp1   = bias_flip(lane_in.p1);
        sp0   = bias_flip(lane_in.p0);
        sq0   = bias_flip(lane_in.q0);
        sq1   = bias_flip(lane_in.q1);
        outer = ssub(sp1, sq1);
        inner = ssub(sq0, sp0);
        acc1  = sadd(outer, inner);
        acc2  = sadd(acc1, inner);
        acc3  = sadd(acc2, inner);

        gate_out.corr = pass ? acc3 : '0;
        gate_out.p0   = lane_in.p0;
        gate_out.q0   = lane_in.q0;
    end
endmodule

// File: rtl/sdf_apply.sv
module sdf_apply
    import sdf_pkg::*;
(
    input  gate_t gate_in,
    output pair_t pair_out
);
    spix_t far_r, near_r, f1, f2;
    logic signed [PIX_W+1:0] q_wide, p_wide;

    always_comb begin
        far_r  = sadd(gate_in.corr, 8'sd4);
        near_r = sadd(gate_in.corr, 8'sd3);
        f1     = far_r >>> 3;
        f2     = near_r >>> 3;
        q_wide = $signed({2'b00, gate_in.q0}) - $signed({{2{f1[PIX_W-1]}}, f1});
        p_wide = $signed({2'b00, gate_in.p0}) + $signed({{2{f2[PIX_W-1]}}, f2});
        pair_out.q0 = clip_u(q_wide);
        pair_out.p0 = clip_u(p_wide);
    end
endmodule

// File: rtl/sdf_core.sv
module sdf_core
    import sdf_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*PIX_W-1:0] in_p1,
    input  logic [LANES*PIX_W-1:0] in_p0,
    input  logic [LANES*PIX_W-1:0] in_q0,
    input  logic [LANES*PIX_W-1:0] in_q1,
    input  logic [PIX_W-1:0]       in_limit,
    output logic                   out_valid,
    output logic [LANES*PIX_W-1:0] out_p0,
    output logic [LANES*PIX_W-1:0] out_q0
);
    localparam int STAGES = 3;

    logic [STAGES-1:0] vld;
    pix_t              lim_r;

    always_ff @(posedge clk) begin
        if (rst)
            vld <= '0;
        else
            vld <= {vld[STAGES-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        lim_r <= in_limit;
    end

    assign out_valid = vld[STAGES-1];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        quad_t s0_q;
        gate_t g_c, s1_g;
        pair_t a_c, s2_r;

        always_ff @(posedge clk) begin
            s0_q.p1 <= in_p1[i*PIX_W +: PIX_W];
            s0_q.p0 <= in_p0[i*PIX_W +: PIX_W];
            s0_q.q0 <= in_q0[i*PIX_W +: PIX_W];
            s0_q.q1 <= in_q1[i*PIX_W +: PIX_W];
            s1_g    <= g_c;
            s2_r    <= a_c;
        end

        sdf_gate u_gate (
            .lane_in (s0_q),
            .limit   (lim_r),
            .gate_out(g_c)
        );

        sdf_apply u_apply (
            .gate_in (s1_g),
            .pair_out(a_c)
        );

        assign out_p0[i*PIX_W +: PIX_W] = s2_r.p0;
        assign out_q0[i*PIX_W +: PIX_W] = s2_r.q0;
    end
endmodule

// File: rtl/sdf_core_chk.sv
module sdf_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] l0_p1,
    input logic [7:0] l0_p0,
    input logic [7:0] l0_q0,
    input logic [7:0] l0_q1,
    input logic [7:0] in_limit,
    input logic       out_valid,
    input logic [7:0] o0_p0,
    input logic [7:0] o0_q0
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // R7: reset empties the pipeline
    assert_rst_clears_R7: assert property (@(posedge clk) rst |=> !out_valid);

    // R6: strobe follows the input three edges later
    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R9: flat lane keeps its inner samples whatever the limit
    assert_flat_lane_R9: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) && $past(in_valid, 3) &&
         ($past(l0_p0, 3) == $past(l0_q0, 3)) && ($past(l0_p1, 3) == $past(l0_q1, 3)))
        |-> ((o0_p0 == $past(l0_p0, 3)) && (o0_q0 == $past(l0_q0, 3))));

    // R9: zero limit blocks any lane with an inner step
    assert_zero_limit_R9: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) && $past(in_valid, 3) && ($past(in_limit, 3) == 8'd0) &&
         ($past(l0_p0, 3) != $past(l0_q0, 3)))
        |-> ((o0_p0 == $past(l0_p0, 3)) && (o0_q0 == $past(l0_q0, 3))));
endmodule

bind sdf_core sdf_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .l0_p1    (in_p1[7:0]),
    .l0_p0    (in_p0[7:0]),
    .l0_q0    (in_q0[7:0]),
    .l0_q1    (in_q1[7:0]),
    .in_limit (in_limit),
    .out_valid(out_valid),
    .o0_p0    (out_p0[7:0]),
    .o0_q0    (out_q0[7:0])
);

// File: tb/sim_sdf_core.sv
`timescale 1ns/1ps
module sim_sdf_core;
    localparam int NL = 16;
    localparam int BW = NL * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_p1 = '0, in_p0 = '0, in_q0 = '0, in_q1 = '0;
    logic [7:0]    in_limit = '0;
    logic          out_valid;
    logic [BW-1:0] out_p0, out_q0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    int sp1[NL], sp0[NL], sq0[NL], sq1[NL];
    int slim;

    bit    ev[3];
    int    ep0[3][NL], eq0[3][NL];
    string etag[3];

    always #5 clk = ~clk;

    sdf_core #(.LANES(NL)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_p1(in_p1), .in_p0(in_p0), .in_q0(in_q0), .in_q1(in_q1),
        .in_limit(in_limit), .out_valid(out_valid),
        .out_p0(out_p0), .out_q0(out_q0)
    );

    function automatic int sclip(int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction

    function automatic int uclip(int v);
        return (v > 255) ? 255 : ((v < 0) ? 0 : v);
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic ref_lane(input int p1, input int p0, input int q0, input int q1,
                            input int lim, output int np0, output int nq0);
        int act, a, d, f1, f2;
        act = iabs(p0 - q0) * 2;
        if (act > 255) act = 255;
        act = act + iabs(p1 - q1) / 2;
        if (act > 255) act = 255;
        a = sclip(p1 - q1);
        d = sclip(q0 - p0);
        a = sclip(a + d);
        a = sclip(a + d);
        a = sclip(a + d);
        if (act > lim) a = 0;
        f1 = sclip(a + 4) >>> 3;
        f2 = sclip(a + 3) >>> 3;
        nq0 = uclip(q0 - f1);
        np0 = uclip(p0 + f2);
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_out();
        check(out_valid === ev[2], "R6", "out_valid", int'(out_valid), int'(ev[2]));
        if (ev[2]) begin
            for (int i = 0; i < NL; i++) begin
                check(out_p0[i*8 +: 8] === 8'(ep0[2][i]), etag[2],
                      $sformatf("lane %0d p0", i), int'(out_p0[i*8 +: 8]), ep0[2][i]);
                check(out_q0[i*8 +: 8] === 8'(eq0[2][i]), etag[2],
                      $sformatf("lane %0d q0", i), int'(out_q0[i*8 +: 8]), eq0[2][i]);
            end
        end
    endtask

    task automatic beat(input bit v, input string tag);
        @(negedge clk);
        compare_out();
        ev[2] = ev[1]; ep0[2] = ep0[1]; eq0[2] = eq0[1]; etag[2] = etag[1];
        ev[1] = ev[0]; ep0[1] = ep0[0]; eq0[1] = eq0[0]; etag[1] = etag[0];
        in_valid = v;
        in_limit = 8'(slim);
        for (int i = 0; i < NL; i++) begin
            int np, nq;
            in_p1[i*8 +: 8] = 8'(sp1[i]);
            in_p0[i*8 +: 8] = 8'(sp0[i]);
            in_q0[i*8 +: 8] = 8'(sq0[i]);
            in_q1[i*8 +: 8] = 8'(sq1[i]);
            ref_lane(sp1[i], sp0[i], sq0[i], sq1[i], slim, np, nq);
            ep0[0][i] = np;
            eq0[0][i] = nq;
        end
        ev[0] = v;
        etag[0] = tag;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) ev[k] = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
        rst = 1'b0;
    endtask

    function automatic int pick_edge();
        int t;
        t = $urandom_range(0, 5);
        case (t)
            0: return 0;
            1: return 255;
            2: return 1;
            3: return 254;
            4: return 127;
            default: return 128;
        endcase
    endfunction

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) ev[k] = 1'b0;
        for (int i = 0; i < NL; i++) begin sp1[i] = 0; sp0[i] = 0; sq0[i] = 0; sq1[i] = 0; end
        slim = 0;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;

        // R1: random lanes, random limit, with bubbles
        for (int c = 0; c < 40; c++) begin
            slim = $urandom_range(0, 255);
            for (int i = 0; i < NL; i++) begin
                sp1[i] = $urandom_range(0, 255); sp0[i] = $urandom_range(0, 255);
                sq0[i] = $urandom_range(0, 255); sq1[i] = $urandom_range(0, 255);
            end
            beat(($urandom_range(0, 3) != 0), "R1");
        end

        // R4: small steps, every lane filtered, rounding offsets matter
        for (int c = 0; c < 30; c++) begin
            slim = 255;
            for (int i = 0; i < NL; i++) begin
                int b;
                b = $urandom_range(20, 235);
                sp1[i] = b + $urandom_range(0, 24) - 12; sp0[i] = b + $urandom_range(0, 24) - 12;
                sq0[i] = b + $urandom_range(0, 24) - 12; sq1[i] = b + $urandom_range(0, 24) - 12;
            end
            beat(1'b1, "R4");
        end

        // R3: low limit and large steps, lanes left alone
        for (int c = 0; c < 20; c++) begin
            slim = $urandom_range(0, 20);
            for (int i = 0; i < NL; i++) begin
                sp0[i] = $urandom_range(0, 100); sq0[i] = sp0[i] + $urandom_range(64, 150);
                sp1[i] = $urandom_range(0, 255); sq1[i] = $urandom_range(0, 255);
            end
            beat(1'b1, "R3");
        end

        // R2: extreme values, signed saturation in the correction
        for (int c = 0; c < 30; c++) begin
            slim = (c % 2) ? 255 : $urandom_range(0, 255);
            for (int i = 0; i < NL; i++) begin
                sp1[i] = pick_edge(); sp0[i] = pick_edge();
                sq0[i] = pick_edge(); sq1[i] = pick_edge();
            end
            beat(1'b1, "R2");
        end

        // R5: inner samples near the rails, unsigned clamping of results
        for (int c = 0; c < 30; c++) begin
            slim = 255;
            for (int i = 0; i < NL; i++) begin
                if ((i + c) % 2) begin
                    sp0[i] = $urandom_range(0, 3);   sq0[i] = $urandom_range(20, 60);
                end else begin
                    sp0[i] = $urandom_range(252, 255); sq0[i] = $urandom_range(195, 235);
                end
                sp1[i] = $urandom_range(0, 255); sq1[i] = $urandom_range(0, 255);
            end
            beat(1'b1, "R5");
        end

        // R8: one active lane per beat, all others flat
        for (int c = 0; c < NL; c++) begin
            slim = 255;
            for (int i = 0; i < NL; i++) begin
                if (i == c) begin
                    sp1[i] = 90; sp0[i] = 100; sq0[i] = 120; sq1[i] = 125;
                end else begin
                    sp1[i] = 60 + i; sp0[i] = 60 + i; sq0[i] = 60 + i; sq1[i] = 60 + i;
                end
            end
            beat(1'b1, "R8");
        end

        // R9: zero limit, then flat lanes under any limit
        for (int c = 0; c < 20; c++) begin
            slim = 0;
            for (int i = 0; i < NL; i++) begin
                sp1[i] = $urandom_range(0, 255); sp0[i] = $urandom_range(0, 255);
                sq0[i] = (sp0[i] + 1 + $urandom_range(0, 200)) % 256; sq1[i] = $urandom_range(0, 255);
            end
            beat(1'b1, "R9");
        end
        for (int c = 0; c < 20; c++) begin
            slim = (c == 0) ? 0 : ((c == 1) ? 255 : $urandom_range(0, 255));
            for (int i = 0; i < NL; i++) begin
                sp0[i] = $urandom_range(0, 255); sq0[i] = sp0[i];
                sp1[i] = $urandom_range(0, 255); sq1[i] = sp1[i];
            end
            beat(1'b1, "R9");
        end

        // R7: reset in mid-stream drops beats in flight
        do_reset();
        for (int c = 0; c < 10; c++) begin
            slim = $urandom_range(0, 255);
            for (int i = 0; i < NL; i++) begin
                sp1[i] = $urandom_range(0, 255); sp0[i] = $urandom_range(0, 255);
                sq0[i] = $urandom_range(0, 255); sq1[i] = $urandom_range(0, 255);
            end
            beat(1'b1, "R6");
        end

        // drain
        for (int c = 0; c < 4; c++) beat(1'b0, "R6");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule